// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register Unit

This unit is the host-facing register file of a descriptor-driven Ethernet controller. The host reaches it through two ports. A write to the index port picks one of four registers. A read or write on the data port then reaches the register that the index names. The four registers are:

- the command/status word,
- the low sixteen bits of the initialization-block address,
- the upper bits of that address,
- a three-bit bus-configuration register.

The transmit and receive engines report events to the unit as single-cycle pulses. The unit latches each one in a sticky flag. It drives level commands (initialize, start, stop) and a one-cycle transmit-demand pulse back to those engines. It also raises an interrupt line.

The host clears an event flag by writing a one to it. The summary error bit and the pending-interrupt bit are computed from the flags and are not stored. A stop request takes priority over every other bit written in the same access. The address and configuration registers accept writes only while the controller is stopped.

Top module: `enet_csr_unit`

## Requirements
- R1: A write with `hst_port`=1 stores `hst_wdata[1:0]` as the register index. While `hst_port`=1, `hst_rdata` shows the index in bits 1:0 and zeros above. Data-port accesses (`hst_port`=0) reach index 0 (command/status), 1 (address low), 2 (address high) or 3 (bus configuration).
- R2: After reset:
  - register 0 reads 0x0004;
  - registers 1 to 3 read zero;
  - the index is 0;
  - `irq`, `ctl_start`, `ctl_init` and `ctl_tx_demand` are low, and `ctl_stop` is high.
- R3: `evt_pulse` bit i sets register 0 bit 8+i on the next clock edge. The bit order is 0 = init done, 1 = transmit done, 2 = receive done, 3 = memory error, 4 = missed frame, 5 = collision error, 6 = babble. Pulses are ignored while register 0 bit 2 (stop) is set.
- R4: Writing a one to any of register 0 bits 14:8 clears that flag. Writing a zero leaves it unchanged. If an event pulse arrives in the same cycle as the clear, the flag stays set.
- R5: Register 0 bit 15 reads as the OR of bits 14:11. Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8; a collision error alone does not set it. Writes to bits 15 and 7 have no effect.
- R6: Register 0 bit 6 is the interrupt enable. It takes the written value on every register 0 write that does not carry stop. `irq` is high exactly when bits 7 and 6 are both set.
- R7: Register 0 bits 5 and 4 read `rx_on` and `tx_on`. Writes to these bits have no effect.
- R8: Writing register 0 bit 3 as one while stopped is clear gives a one-cycle `ctl_tx_demand` pulse in the cycle after the write. The write is ignored while stopped. Bit 3 always reads zero.
- R9: Writing register 0 bit 2 as one does all of the following, whatever bits 1 and 0 carry in the same write:
  - sets stop;
  - clears start, init, interrupt enable and all event flags.
- R10: Writing register 0 bit 1 (start) or bit 0 (init) as one, with bit 2 zero, sets that bit and clears stop. Writing zero to either bit does not clear it. `ctl_stop`, `ctl_start` and `ctl_init` follow bits 2, 1 and 0.
- R11: Register 1 holds `iba_addr[15:0]`. Register 2 holds `iba_addr[23:16]` in bits 7:0 and reads zero above them. Register 3 holds byte swap in bit 2, address-latch mode in bit 1 and byte-strobe mode in bit 0, and reads zero above them.
- R12: Writes to registers 1 to 3 take effect only while stop is set. At other times they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_port | input | 1 | 1 = index port, 0 = data port |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Read view of the selected port |
| evt_pulse | input | 7 | Event pulses from the engines (order as in R3) |
| rx_on | input | 1 | Receiver running status |
| tx_on | input | 1 | Transmitter running status |
| ctl_init | output | 1 | Initialize command level |
| ctl_start | output | 1 | Start command level |
| ctl_stop | output | 1 | Stop command level |
| ctl_tx_demand | output | 1 | Transmit-demand pulse |
| irq | output | 1 | Interrupt request |
| iba_addr | output | 24 | Initialization-block address |
| cfg_byte_swap | output | 1 | Byte-swap configuration |
| cfg_ale_mode | output | 1 | Address-latch mode configuration |
| cfg_byte_mode | output | 1 | Byte-strobe mode configuration |

## Verification
The assertions check the following on every cycle:
- a stop write clears the whole command state and the flags;
- an event beats a same-cycle clear;
- flags do not rise while stopped;
- the configuration stays frozen while running;
- a start or init write releases stop;
- the index port is loaded correctly;
- `irq` is never raised while stopped.

The following can be shown only by the bench, whose reference model runs a seeded random mix of writes and event pulses plus directed corner cases:
- the read values of register 0, namely the summary error bit, the pending-interrupt bit that leaves collision errors out, and the status mirrors;
- the exact cycle of the transmit-demand pulse;
- the read-back of the address and configuration registers.

// File: rtl/enet_csr_pkg.sv
package enet_csr_pkg;
  localparam int DW      = 16;
  localparam int NEV     = 7;
  localparam int EV_LSB  = 8;
  localparam int B_ERR   = 15;
  localparam int B_PEND  = 7;
  localparam int B_IEN   = 6;
  localparam int B_RXON  = 5;
  localparam int B_TXON  = 4;
  localparam int B_TDEM  = 3;
  localparam int B_STOP  = 2;
  localparam int B_STRT  = 1;
  localparam int B_INIT  = 0;
  // flags that count toward the pending-interrupt summary (collision excluded)
  localparam logic [NEV-1:0] IRQ_SRC_MASK = 7'b1011111;
  // flags that count toward the error summary
  localparam logic [NEV-1:0] ERR_SRC_MASK = 7'b1111000;

  typedef enum logic [1:0] {
    IX_CMD    = 2'd0,
    IX_IBA_LO = 2'd1,
    IX_IBA_HI = 2'd2,
    IX_BUSCFG = 2'd3
  } csr_idx_e;

  function automatic logic err_of(input logic [NEV-1:0] ev);
    return |(ev & ERR_SRC_MASK);
  endfunction

  function automatic logic pend_of(input logic [NEV-1:0] ev);
    return |(ev & IRQ_SRC_MASK);
  endfunction
endpackage

// File: rtl/csr_evt_bank.sv
module csr_evt_bank #(
  parameter int NEV = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_pulse,
  input  logic [NEV-1:0] clr_mask,
  input  logic           flush,
  input  logic           hold,
  output logic [NEV-1:0] evt_q
);
  for (genvar g = 0; g < NEV; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flag_q <= 1'b0;
      else if (flush)                  flag_q <= 1'b0;
      else if (!hold && evt_pulse[g])  flag_q <= 1'b1;
      else if (clr_mask[g])            flag_q <= 1'b0;
    end
    assign evt_q[g] = flag_q;
  end

  // R9: a stop request empties every flag
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (evt_q == '0));
  // R4: an accepted event survives a same-cycle clear
  p_event_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !hold) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));
  // R3: no flag rises while held
  p_hold_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ((evt_q & ~$past(evt_q)) == '0));
endmodule

// File: rtl/csr_cmd_ctl.sv
module csr_cmd_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd,
  input  logic w_stop,
  input  logic w_strt,
  input  logic w_init,
  input  logic w_tdem,
  input  logic w_ien,
  output logic stop_q,
  output logic strt_q,
  output logic init_q,
  output logic ien_q,
  output logic tdem_q,
  output logic stop_req
);
  logic go_req;
  assign stop_req = wr_cmd & w_stop;
  assign go_req   = wr_cmd & ~w_stop & (w_strt | w_init);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      strt_q <= 1'b0;
      init_q <= 1'b0;
      ien_q  <= 1'b0;
      tdem_q <= 1'b0;
    end else if (stop_req) begin
      stop_q <= 1'b1;
      strt_q <= 1'b0;
      init_q <= 1'b0;
      ien_q  <= 1'b0;
      tdem_q <= 1'b0;
    end else begin
      tdem_q <= wr_cmd & w_tdem & ~stop_q;
      if (wr_cmd)          ien_q  <= w_ien;
      if (go_req)          stop_q <= 1'b0;
      if (wr_cmd & w_strt) strt_q <= 1'b1;
      if (wr_cmd & w_init) init_q <= 1'b1;
    end
  end

  // R9: stop wins over start/init carried in the same write
  p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (stop_q && !strt_q && !init_q && !ien_q));
  // R10: a start or init write releases stop
  p_go_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |=> !stop_q);
  // R8: a demand pulse only follows a command write made while running
  p_tdem_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tdem_q |-> $past(wr_cmd && !stop_q));
endmodule

// File: rtl/csr_cfg_bank.sv
module csr_cfg_bank #(
  parameter int IBA_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data,
  input  logic [1:0]       idx,
  input  logic [15:0]      wd,
  input  logic             unlocked,
  output logic [IBA_W-1:0] iba_q,
  output logic [2:0]       cfg_q
);
  import enet_csr_pkg::*;
  localparam int HI_W = IBA_W - DW;

  logic wr_ok;
  assign wr_ok = wr_data & unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iba_q <= '0;
      cfg_q <= '0;
    end else if (wr_ok) begin
      case (csr_idx_e'(idx))
        IX_IBA_LO: iba_q[DW-1:0]     <= wd;
        IX_IBA_HI: iba_q[IBA_W-1:DW] <= wd[HI_W-1:0];
        IX_BUSCFG: cfg_q             <= wd[2:0];
        default:   ;
      endcase
    end
  end

  // R12: nothing here moves while the controller runs
  p_frozen_running_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(iba_q) && $stable(cfg_q)));
endmodule

// File: rtl/enet_csr_unit.sv
module enet_csr_unit #(
  parameter int IBA_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_wr,
  input  logic             hst_port,
  input  logic [15:0]      hst_wdata,
  output logic [15:0]      hst_rdata,
  input  logic [6:0]       evt_pulse,
  input  logic             rx_on,
  input  logic             tx_on,
  output logic             ctl_init,
  output logic             ctl_start,
  output logic             ctl_stop,
  output logic             ctl_tx_demand,
  output logic             irq,
  output logic [IBA_W-1:0] iba_addr,
  output logic             cfg_byte_swap,
  output logic             cfg_ale_mode,
  output logic             cfg_byte_mode
);
  import enet_csr_pkg::*;
  localparam int HI_W = IBA_W - DW;

  logic [1:0]     idx_q;
  logic           wr_idx, wr_data, wr_cmd;
  logic           stop_q, strt_q, init_q, ien_q, tdem_q, stop_req;
  logic [NEV-1:0] evt_q, clr_mask;
  logic [2:0]     cfg_q;
  logic [15:0]    cmd_view, data_view;
  logic           pend;

  assign wr_idx   = hst_wr & hst_port;
  assign wr_data  = hst_wr & ~hst_port;
  assign wr_cmd   = wr_data & (csr_idx_e'(idx_q) == IX_CMD);
  assign clr_mask = wr_cmd ? hst_wdata[EV_LSB +: NEV] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (wr_idx) idx_q <= hst_wdata[1:0];
  end

  csr_cmd_ctl u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd),
    .w_stop(hst_wdata[B_STOP]), .w_strt(hst_wdata[B_STRT]),
    .w_init(hst_wdata[B_INIT]), .w_tdem(hst_wdata[B_TDEM]),
    .w_ien(hst_wdata[B_IEN]),
    .stop_q(stop_q), .strt_q(strt_q), .init_q(init_q), .ien_q(ien_q),
    .tdem_q(tdem_q), .stop_req(stop_req)
  );

  csr_evt_bank #(.NEV(NEV)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .clr_mask(clr_mask),
    .flush(stop_req), .hold(stop_q), .evt_q(evt_q)
  );

  csr_cfg_bank #(.IBA_W(IBA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .idx(idx_q), .wd(hst_wdata),
    .unlocked(stop_q), .iba_q(iba_addr), .cfg_q(cfg_q)
  );

  assign pend = pend_of(evt_q);

  always_comb begin
    cmd_view                      = '0;
    cmd_view[B_ERR]               = err_of(evt_q);
    cmd_view[EV_LSB +: NEV]       = evt_q;
    cmd_view[B_PEND]              = pend;
    cmd_view[B_IEN]               = ien_q;
    cmd_view[B_RXON]              = rx_on;
    cmd_view[B_TXON]              = tx_on;
    cmd_view[B_STOP]              = stop_q;
    cmd_view[B_STRT]              = strt_q;
    cmd_view[B_INIT]              = init_q;
  end

  always_comb begin
    data_view = '0;
    case (csr_idx_e'(idx_q))
      IX_CMD:    data_view = cmd_view;
      IX_IBA_LO: data_view = iba_addr[DW-1:0];
      IX_IBA_HI: data_view[HI_W-1:0] = iba_addr[IBA_W-1:DW];
      default:   data_view[2:0] = cfg_q;
    endcase
  end

  assign hst_rdata     = hst_port ? {14'b0, idx_q} : data_view;
  assign irq           = pend & ien_q;
  assign ctl_stop      = stop_q;
  assign ctl_start     = strt_q;
  assign ctl_init      = init_q;
  assign ctl_tx_demand = tdem_q;
  assign cfg_byte_swap = cfg_q[2];
  assign cfg_ale_mode  = cfg_q[1];
  assign cfg_byte_mode = cfg_q[0];

  // R1: an index-port write loads the index
  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> (idx_q == $past(hst_wdata[1:0])));
  // R6: no interrupt can be raised while stopped
  p_no_irq_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ctl_stop);
endmodule

// File: tb/enet_csr_unit_tb_top.sv
module enet_csr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0, hst_port = 1'b0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic [6:0]  evt_pulse = '0;
  logic        rx_on = 1'b0, tx_on = 1'b0;
  logic        ctl_init, ctl_start, ctl_stop, ctl_tx_demand, irq;
  logic [23:0] iba_addr;
  logic        cfg_byte_swap, cfg_ale_mode, cfg_byte_mode;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  enet_csr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_port(hst_port),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .evt_pulse(evt_pulse),
    .rx_on(rx_on), .tx_on(tx_on), .ctl_init(ctl_init), .ctl_start(ctl_start),
    .ctl_stop(ctl_stop), .ctl_tx_demand(ctl_tx_demand), .irq(irq),
    .iba_addr(iba_addr), .cfg_byte_swap(cfg_byte_swap),
    .cfg_ale_mode(cfg_ale_mode), .cfg_byte_mode(cfg_byte_mode)
  );

  // reference state
  logic [1:0]  m_idx;
  logic [6:0]  m_ev;
  logic        m_stop, m_strt, m_init, m_ien, m_tdem;
  logic [23:0] m_iba;
  logic [2:0]  m_cfg;

  function automatic logic [15:0] exp_cmd();
    logic err, pend;
    err  = m_ev[6] | m_ev[5] | m_ev[4] | m_ev[3];
    pend = m_ev[6] | m_ev[4] | m_ev[3] | m_ev[2] | m_ev[1] | m_ev[0];
    return {err, m_ev, pend, m_ien, rx_on, tx_on, 1'b0, m_stop, m_strt, m_init};
  endfunction

  function automatic logic [15:0] exp_data();
    case (m_idx)
      2'd0: return exp_cmd();
      2'd1: return m_iba[15:0];
      2'd2: return {8'h00, m_iba[23:16]};
      default: return {13'b0, m_cfg};
    endcase
  endfunction

  function automatic logic exp_irq();
    logic [15:0] c;
    c = exp_cmd();
    return c[7] & c[6];
  endfunction

  task automatic model_reset();
    m_idx = 0; m_ev = 0; m_stop = 1; m_strt = 0; m_init = 0; m_ien = 0;
    m_tdem = 0; m_iba = 0; m_cfg = 0;
  endtask

  // applies the inputs present at the edge to the reference state
  task automatic model_edge();
    logic       wcmd, old_stop;
    logic [6:0] ev_n;
    old_stop = m_stop;
    wcmd = hst_wr && !hst_port && m_idx == 2'd0;
    ev_n = m_ev;
    if (wcmd) ev_n = ev_n & ~hst_wdata[14:8];
    if (!old_stop) ev_n = ev_n | evt_pulse;
    m_tdem = 1'b0;
    if (wcmd && hst_wdata[2]) begin
      m_stop = 1; m_strt = 0; m_init = 0; m_ien = 0; ev_n = 0;
    end else if (wcmd) begin
      m_tdem = hst_wdata[3] & ~old_stop;
      m_ien  = hst_wdata[6];
      if (hst_wdata[1]) m_strt = 1;
      if (hst_wdata[0]) m_init = 1;
      if (hst_wdata[1] | hst_wdata[0]) m_stop = 0;
    end
    m_ev = ev_n;
    if (hst_wr && !hst_port && old_stop) begin
      if (m_idx == 2'd1) m_iba[15:0]  = hst_wdata;
      if (m_idx == 2'd2) m_iba[23:16] = hst_wdata[7:0];
      if (m_idx == 2'd3) m_cfg        = hst_wdata[2:0];
    end
    if (hst_wr && hst_port) m_idx = hst_wdata[1:0];
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  // one clock: inputs are already driven; update model at edge; idle inputs
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    hst_wr = 0; hst_port = 0; hst_wdata = '0; evt_pulse = '0;
    #1;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R5/R7 data view"}, {16'h0, hst_rdata}, {16'h0, exp_data()});
    chk({tag, " R6 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    chk({tag, " R10 ctl"}, {29'h0, ctl_stop, ctl_start, ctl_init},
        {29'h0, m_stop, m_strt, m_init});
    chk({tag, " R8 tx_demand"}, {31'h0, ctl_tx_demand}, {31'h0, m_tdem});
    chk({tag, " R11 iba/cfg"}, {5'h0, iba_addr, cfg_byte_swap, cfg_ale_mode, cfg_byte_mode},
        {5'h0, m_iba, m_cfg});
  endtask

  task automatic wr(input logic port, input logic [15:0] d);
    hst_wr = 1; hst_port = port; hst_wdata = d;
    step();
  endtask

  initial begin : watchdog
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R2: reset state
    chk("R2 reg0", {16'h0, hst_rdata}, 32'h0004);
    chk("R2 ctl", {28'h0, ctl_stop, ctl_start, ctl_init, irq}, 32'h8);
    hst_port = 1; #1;
    chk("R2 index", {16'h0, hst_rdata}, 32'h0);
    hst_port = 0;

    // R12: configuration writable while stopped
    wr(1, 16'h0001); chk("R1 index load", {30'h0, m_idx}, 32'h1);
    hst_port = 1; #1; chk("R1 index read", {16'h0, hst_rdata}, 32'h1); hst_port = 0;
    wr(0, 16'hBEEF);
    wr(1, 16'h0002); wr(0, 16'hFF5A);
    wr(1, 16'h0003); wr(0, 16'hFFFD);
    check_all("R11 stopped");
    chk("R11 reg3 read", {16'h0, hst_rdata}, 32'h0005);

    // R3: events ignored while stopped
    wr(1, 16'h0000);
    evt_pulse = 7'h7F; step();
    chk("R3 ignored while stopped", {16'h0, hst_rdata}, 32'h0004);

    // R9: stop wins over start+init
    wr(0, 16'h0047);
    chk("R9 stop wins", {29'h0, ctl_stop, ctl_start, ctl_init}, 32'h4);

    // R10: start releases stop, IEN set
    wr(0, 16'h0042);
    chk("R10 started", {29'h0, ctl_stop, ctl_start, ctl_init}, 32'h2);
    wr(0, 16'h0040);
    chk("R10 zero keeps start", {31'h0, ctl_start}, 32'h1);

    // R12: cfg writes ignored while running
    wr(1, 16'h0003); wr(0, 16'h0002);
    chk("R12 cfg frozen", {29'h0, cfg_byte_swap, cfg_ale_mode, cfg_byte_mode}, 32'h5);
    wr(1, 16'h0000);

    // R5/R6: collision alone sets error but not pending/irq
    evt_pulse = 7'b0100000; step();
    chk("R5 collision only", {16'h0, hst_rdata}, {16'h0, exp_cmd()});
    chk("R5 collision err bit", {31'h0, hst_rdata[15]}, 32'h1);
    chk("R6 no irq on collision", {31'h0, irq}, 32'h0);

    // R4: event beats same-cycle clear
    evt_pulse = 7'b0000100; step();
    chk("R6 irq on receive", {31'h0, irq}, 32'h1);
    hst_wr = 1; hst_port = 0; hst_wdata = 16'h2440; evt_pulse = 7'b0000100; step();
    chk("R4 set beats clear", {31'h0, hst_rdata[10]}, 32'h1);
    chk("R4 collision cleared", {31'h0, hst_rdata[13]}, 32'h0);
    wr(0, 16'h0440);
    chk("R4 cleared", {16'h0, hst_rdata & 16'hFF00}, 32'h0);

    // R8: transmit demand pulse
    wr(0, 16'h0048);
    chk("R8 pulse", {31'h0, ctl_tx_demand}, 32'h1);
    chk("R8 reads zero", {31'h0, hst_rdata[3]}, 32'h0);
    step();
    chk("R8 one cycle", {31'h0, ctl_tx_demand}, 32'h0);

    // R7: status mirrors
    rx_on = 1; tx_on = 0; #1;
    chk("R7 mirrors", {30'h0, hst_rdata[5:4]}, 32'h2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      evt_pulse = 7'($urandom & $urandom & $urandom);
      rx_on = 1'($urandom); tx_on = 1'($urandom);
      if (($urandom % 10) < 4) begin
        hst_wr = 1;
        hst_port = (($urandom % 4) == 0);
        hst_wdata = 16'($urandom);
        if (($urandom % 8) != 0) hst_wdata[2] = 1'b0;
      end
      step();
      check_all("R3/R4 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule